// File: doc/BRIEF.md
# Parity-Protected Row Buffer with Initialization Gating

This block holds two parity-protected on-chip memories behind one 32-bit register-style port. It also holds a small control and status register. The first memory is a writable buffer built from 128-bit rows, each made of four 32-bit lanes. A single write to lane 0 of a row fills all four lanes with the written word and fresh parity. Software can therefore clear the whole buffer with exactly one write per row. The second memory is a bank of 32-bit counters. Software can only read it, and the surrounding packet logic can only increment it. A hardware walker clears this counter bank, one entry per clock, after power-up reset and after every soft reset.

Every 32-bit lane stores one even-parity bit, and a read checks the lane it returns. A parity mismatch raises a sticky per-memory error flag, but only once software has cleared that memory's error-disable bit. Both disable bits are set again by every reset. As a result, random contents left over from power-up cannot raise an error before software has initialized the memory. The recovery sequence is a soft reset, then a full row-fill pass over the affected memory, then clearing the disable bit. The soft reset leaves the buffer contents intact.

Top module: `par_buf_top`

## Requirements
- R1: A write to lane 0 of a buffer row (byte address bits 3:2 equal 0) stores the written word in all four lanes of that row, each with fresh parity. Later reads of byte offsets 0, 4, 8 and 12 of the row return that word and raise no parity error. The row is selected by byte-address bits above bit 3.
- R2: A write to lane 1, 2 or 3 of a buffer row replaces only that lane. The other three lanes keep their values.
- R3: A read request accepted on a clock edge produces `rsp_valid` high with the data, for exactly the following cycle. Writes produce no response.
- R4: After power-up reset and after a `soft_rst` pulse, the status word (`req_sel`=2) reads 0x0000_0300. In that word, bits 9:8 are the disable bits (buffer, counters) and bits 1:0 are the error flags (buffer, counters).
- R5: While a memory's disable bit is set, a parity mismatch on a read of that memory leaves its error flag at 0.
- R6: While the disable bit is clear, a read whose lane data disagrees with its stored even-parity bit sets that memory's flag on the cycle after the response. The flag stays set until it is cleared.
- R7: A status write clears error flag bit k for each 1 in wdata bit k (k = 0, 1). It clears disable bit k for each 1 in wdata bit 8+k. Zeros have no effect, and software can never set a disable bit.
- R8: After any reset, `stat_busy` is high for exactly STAT_ROWS cycles while the walker zeroes every counter. Counter reads during busy return 0 without a parity check.
- R9: `stat_inc` adds one to the addressed counter when busy is low and is ignored while busy is high. Port writes with `req_sel`=1 never change a counter. Counter k is read at byte address 4*k.
- R10: A soft reset keeps buffer contents. After the soft reset and a full row-fill pass, reads of a previously faulty row return the new data, and no error is flagged once the disable bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| soft_rst | input | 1 | Synchronous soft reset pulse |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | Target: 0 buffer, 1 counters, 2 status |
| req_addr | input | AW | Byte address (AW = log2(ROWS)+4) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| stat_inc | input | 1 | Counter increment strobe |
| stat_inc_idx | input | SW | Counter to increment (SW = log2(STAT_ROWS)) |
| stat_busy | output | 1 | Hardware clear in progress |

## Verification
The embedded assertions check several rules on every cycle. An error flag may only rise when its disable bit was clear, and only after a response from that memory. A flag stays set unless it is cleared. A disable bit never returns to 1 except through reset. A soft reset always restores the status state. The walker ends on the last entry, and reads during busy return zero. Response timing follows the request by one cycle. Other behaviour only the bench's scenarios can show: lane fill and lane isolation, how garbage contents and injected parity faults interact with the disable bits, counter increments, and the full recovery sequence of soft reset and re-initialization.

// File: rtl/par_buf_pkg.sv
package par_buf_pkg;
    typedef enum logic [1:0] {
        SEL_BUF  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CSR  = 2'd2
    } sel_e;

    localparam int LANE_W = 32;
    localparam int LANES  = 4;
endpackage

// File: rtl/pb_row_mem.sv
module pb_row_mem #(
    parameter int ROWS = 64,
    localparam int RW = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_row,
    input  logic [1:0]    wr_lane,
    input  logic [31:0]   wr_data,
    input  logic          rd_en,
    input  logic [RW-1:0] rd_row,
    input  logic [1:0]    rd_lane,
    output logic [31:0]   rd_data_o,
    output logic          rd_perr_o
);
    typedef struct packed {
        logic [31:0] data;
        logic        perr;
    } rd_t;

    logic [127:0] data_q [ROWS];
    logic [3:0]   par_q  [ROWS];
    rd_t          rd_d, rd_q;
    logic [31:0]  lane_data;
    logic         lane_par;

    always_comb begin
        lane_data = data_q[rd_row][{rd_lane, 5'd0} +: 32];
        lane_par  = par_q[rd_row][rd_lane];
        rd_d      = rd_q;
        if (rd_en) begin
            rd_d.data = lane_data;
            rd_d.perr = (^lane_data) != lane_par;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_lane == 2'd0) begin
                data_q[wr_row] <= {4{wr_data}};
                par_q[wr_row]  <= {4{^wr_data}};
            end else begin
                data_q[wr_row][{wr_lane, 5'd0} +: 32] <= wr_data;
                par_q[wr_row][wr_lane]                <= ^wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data_o = rd_q.data;
    assign rd_perr_o = rd_q.perr;
endmodule

// File: rtl/pb_stat_mem.sv
module pb_stat_mem #(
    parameter int ENTRIES = 16,
    localparam int SW = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          inc_en,
    input  logic [SW-1:0] inc_idx,
    input  logic          rd_en,
    input  logic [SW-1:0] rd_idx,
    output logic [31:0]   rd_data_o,
    output logic          rd_perr_o,
    output logic          busy_o
);
    localparam logic [SW-1:0] LAST = SW'(ENTRIES - 1);

    typedef struct packed {
        logic          busy;
        logic [SW-1:0] ptr;
        logic [31:0]   rd_data;
        logic          rd_perr;
    } st_t;

    logic [31:0]        cnt_q [ENTRIES];
    logic [ENTRIES-1:0] spar_q;
    st_t                st_d, st_q;
    logic               wr_en;
    logic [SW-1:0]      wr_idx;
    logic [31:0]        wr_val;

    always_comb begin
        st_d   = st_q;
        wr_en  = 1'b0;
        wr_idx = st_q.ptr;
        wr_val = '0;
        if (st_q.busy) begin
            wr_en = 1'b1;
            if (st_q.ptr == LAST) st_d.busy = 1'b0;
            else                  st_d.ptr  = st_q.ptr + 1'b1;
        end else if (inc_en) begin
            wr_en  = 1'b1;
            wr_idx = inc_idx;
            wr_val = cnt_q[inc_idx] + 32'd1;
        end
        if (rd_en) begin
            if (st_q.busy) begin
                st_d.rd_data = '0;
                st_d.rd_perr = 1'b0;
            end else begin
                st_d.rd_data = cnt_q[rd_idx];
                st_d.rd_perr = (^cnt_q[rd_idx]) != spar_q[rd_idx];
            end
        end
        if (soft_rst) begin
            st_d.busy = 1'b1;
            st_d.ptr  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && rst_n) begin
            cnt_q[wr_idx]  <= wr_val;
            spar_q[wr_idx] <= ^wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{busy: 1'b1, ptr: '0, rd_data: '0, rd_perr: 1'b0};
        else        st_q <= st_d;
    end

    assign rd_data_o = st_q.rd_data;
    assign rd_perr_o = st_q.rd_perr;
    assign busy_o    = st_q.busy;

    AST_WALK_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> $past(st_q.ptr) == LAST); // R8
    AST_BUSY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && rd_en) |=> (rd_data_o == 32'd0 && !rd_perr_o)); // R8
endmodule

// File: rtl/pb_err_ctl.sv
module pb_err_ctl (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic [1:0]  perr_i,
    input  logic        csr_wr,
    input  logic [31:0] csr_wdata,
    output logic [1:0]  err_o,
    output logic [1:0]  dis_o
);
    typedef struct packed {
        logic [1:0] err;
        logic [1:0] dis;
    } ec_t;

    ec_t ec_d, ec_q;

    always_comb begin
        ec_d = ec_q;
        if (csr_wr) begin
            ec_d.err = ec_q.err & ~csr_wdata[1:0];
            ec_d.dis = ec_q.dis & ~csr_wdata[9:8];
        end
        ec_d.err = ec_d.err | (perr_i & ~ec_q.dis);
        if (soft_rst) begin
            ec_d.err = 2'b00;
            ec_d.dis = 2'b11;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ec_q <= '{err: 2'b00, dis: 2'b11};
        else        ec_q <= ec_d;
    end

    assign err_o = ec_q.err;
    assign dis_o = ec_q.dis;

    AST_SOFT_RST_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ec_q.dis == 2'b11 && ec_q.err == 2'b00)); // R4
    AST_DIS_GATES_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ec_q.err[0]) |-> !$past(ec_q.dis[0])); // R5
    AST_DIS_GATES_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ec_q.err[1]) |-> !$past(ec_q.dis[1])); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ec_q.err[0] && !soft_rst && !(csr_wr && csr_wdata[0])) |=> ec_q.err[0]); // R6
    AST_DIS_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ec_q.dis[0] && !soft_rst) |=> !ec_q.dis[0]); // R7
endmodule

// File: rtl/par_buf_top.sv
module par_buf_top
    import par_buf_pkg::*;
#(
    parameter int ROWS      = 64,
    parameter int STAT_ROWS = 16,
    localparam int AW = $clog2(ROWS) + 4,
    localparam int SW = $clog2(STAT_ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [1:0]    req_sel,
    input  logic [AW-1:0] req_addr,
    input  logic [31:0]   req_wdata,
    output logic          rsp_valid,
    output logic [31:0]   rsp_rdata,
    input  logic          stat_inc,
    input  logic [SW-1:0] stat_inc_idx,
    output logic          stat_busy
);
    typedef struct packed {
        logic        valid;
        logic [1:0]  sel;
        logic [31:0] csr;
    } rsp_t;

    rsp_t        rsp_d, rsp_q;
    logic        buf_wr, buf_rd, stat_rd, csr_wr;
    logic [31:0] buf_rdata, stat_rdata;
    logic        buf_perr, stat_perr;
    logic [1:0]  perr_vec, err, dis;

    always_comb begin
        buf_wr  = req_valid &&  req_write && req_sel == SEL_BUF;
        buf_rd  = req_valid && !req_write && req_sel == SEL_BUF;
        stat_rd = req_valid && !req_write && req_sel == SEL_STAT;
        csr_wr  = req_valid &&  req_write && req_sel == SEL_CSR;

        rsp_d.valid = req_valid && !req_write && !soft_rst;
        rsp_d.sel   = req_sel;
        rsp_d.csr   = {22'd0, dis, 6'd0, err};

        perr_vec[0] = rsp_q.valid && rsp_q.sel == SEL_BUF  && buf_perr;
        perr_vec[1] = rsp_q.valid && rsp_q.sel == SEL_STAT && stat_perr;

        case (rsp_q.sel)
            SEL_BUF:  rsp_rdata = buf_rdata;
            SEL_STAT: rsp_rdata = stat_rdata;
            SEL_CSR:  rsp_rdata = rsp_q.csr;
            default:  rsp_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;

    pb_row_mem #(.ROWS(ROWS)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (buf_wr),
        .wr_row   (req_addr[AW-1:4]),
        .wr_lane  (req_addr[3:2]),
        .wr_data  (req_wdata),
        .rd_en    (buf_rd),
        .rd_row   (req_addr[AW-1:4]),
        .rd_lane  (req_addr[3:2]),
        .rd_data_o(buf_rdata),
        .rd_perr_o(buf_perr)
    );

    pb_stat_mem #(.ENTRIES(STAT_ROWS)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .inc_en   (stat_inc),
        .inc_idx  (stat_inc_idx),
        .rd_en    (stat_rd),
        .rd_idx   (req_addr[SW+1:2]),
        .rd_data_o(stat_rdata),
        .rd_perr_o(stat_perr),
        .busy_o   (stat_busy)
    );

    pb_err_ctl u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .perr_i   (perr_vec),
        .csr_wr   (csr_wr),
        .csr_wdata(req_wdata),
        .err_o    (err),
        .dis_o    (dis)
    );

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write)); // R3
    AST_FLAG_FROM_BUF_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err[0]) |-> $past(rsp_q.valid && rsp_q.sel == SEL_BUF)); // R6
endmodule

// File: tb/par_buf_top_bench.sv
module par_buf_top_bench;
    localparam int ROWS = 64;
    localparam int STAT_ROWS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_sel = 2'd0;
    logic [9:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        stat_inc = 1'b0;
    logic [3:0]  stat_inc_idx = '0;
    logic        stat_busy;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    par_buf_top #(.ROWS(ROWS), .STAT_ROWS(STAT_ROWS)) u_par_buf_top (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .req_valid(req_valid), .req_write(req_write), .req_sel(req_sel),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .stat_inc(stat_inc), .stat_inc_idx(stat_inc_idx), .stat_busy(stat_busy)
    );

    typedef struct packed {
        logic        wr;
        logic [9:0]  addr;
        logic [31:0] data;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{1'b1, 10'h010, 32'hAAAA_0001},
        '{1'b0, 10'h010, 32'hAAAA_0001},
        '{1'b0, 10'h014, 32'hAAAA_0001},
        '{1'b0, 10'h018, 32'hAAAA_0001},
        '{1'b0, 10'h01C, 32'hAAAA_0001},
        '{1'b1, 10'h018, 32'h5555_0003},
        '{1'b0, 10'h018, 32'h5555_0003},
        '{1'b0, 10'h014, 32'hAAAA_0001},
        '{1'b0, 10'h01C, 32'hAAAA_0001},
        '{1'b0, 10'h010, 32'hAAAA_0001},
        '{1'b1, 10'h3F0, 32'hFFFF_FFFF},
        '{1'b0, 10'h3FC, 32'hFFFF_FFFF}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] s, input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_sel = s; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] s, input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_sel = s; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_valid ? rsp_rdata : 32'hDEAD_BEEF;
    endtask

    task automatic read_status(output logic [31:0] d);
        @(negedge clk);
        bus_read(2'd2, 10'h000, d);
    endtask

    task automatic fill_all(input logic [31:0] base);
        for (int r = 0; r < ROWS; r++) bus_write(2'd0, 10'(r * 16), base + 32'(r));
    endtask

    task automatic pulse_soft_rst();
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        repeat (STAT_ROWS + 2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int bad;
        #1;
        for (int r = 0; r < ROWS; r++) begin
            u_par_buf_top.u_buf.data_q[r] = {4{32'h0000_0001}};
            u_par_buf_top.u_buf.par_q[r]  = 4'b0000;
        end
        for (int k = 0; k < STAT_ROWS; k++) begin
            u_par_buf_top.u_stat.cnt_q[k]  = 32'h0000_0007;
            u_par_buf_top.u_stat.spar_q[k] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R8: read a counter right after release, while busy
        req_valid = 1'b1; req_write = 1'b0; req_sel = 2'd1; req_addr = 10'h00C;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 read during busy is zero", rsp_rdata, 32'd0);
        chk("R8 busy after 1 cycle", {31'd0, stat_busy}, 32'd1);
        repeat (STAT_ROWS - 2) @(negedge clk);
        chk("R8 busy at cycle STAT_ROWS-1", {31'd0, stat_busy}, 32'd1);
        @(negedge clk);
        chk("R8 busy low at cycle STAT_ROWS", {31'd0, stat_busy}, 32'd0);

        read_status(d);
        chk("R4 status after power-up", d, 32'h0000_0300);

        // R5: garbage row read with disable set
        bus_read(2'd0, 10'h090, d);
        read_status(d);
        chk("R5 no flag on garbage while disabled", d, 32'h0000_0300);

        // R1 R2 R3: vector table
        foreach (VECS[i]) begin
            if (VECS[i].wr) bus_write(2'd0, VECS[i].addr, VECS[i].data);
            else begin
                bus_read(2'd0, VECS[i].addr, d);
                chk("R1/R2/R3 table read", d, VECS[i].data);
            end
        end

        // R1: full row-fill pass, then enable reporting
        fill_all(32'hC0DE_0000);
        bus_write(2'd2, 10'h000, 32'h0000_0300);
        read_status(d);
        chk("R7 disable bits cleared", d, 32'h0000_0000);
        bad = 0;
        for (int r = 0; r < ROWS; r++)
            for (int l = 0; l < 4; l++) begin
                bus_read(2'd0, 10'(r * 16 + l * 4), d);
                if (d !== 32'hC0DE_0000 + 32'(r)) bad++;
            end
        chk("R1 full pass readback mismatches", 32'(bad), 32'd0);
        read_status(d);
        chk("R1 no error after full pass", d, 32'h0000_0000);

        // R9: counters
        @(negedge clk);
        stat_inc = 1'b1; stat_inc_idx = 4'd2;
        repeat (3) @(negedge clk);
        stat_inc = 1'b0;
        bus_read(2'd1, 10'h008, d);
        chk("R9 three increments", d, 32'd3);
        bus_write(2'd1, 10'h008, 32'h1234_5678);
        bus_read(2'd1, 10'h008, d);
        chk("R9 port write ignored", d, 32'd3);
        bus_read(2'd1, 10'h014, d);
        chk("R8 walker cleared garbage", d, 32'd0);
        read_status(d);
        chk("R8 no counter error after walk", d, 32'h0000_0000);

        // R6 R7: buffer fault
        @(negedge clk);
        u_par_buf_top.u_buf.par_q[5][0] = ~u_par_buf_top.u_buf.par_q[5][0];
        bus_read(2'd0, 10'h050, d);
        read_status(d);
        chk("R6 buffer flag raised", d, 32'h0000_0001);
        bus_write(2'd2, 10'h000, 32'h0000_0002);
        read_status(d);
        chk("R7 zero bit keeps flag", d, 32'h0000_0001);
        bus_write(2'd2, 10'h000, 32'h0000_0001);
        read_status(d);
        chk("R7 write-one clears flag", d, 32'h0000_0000);
        bus_write(2'd2, 10'h000, 32'h0000_0300);
        read_status(d);
        chk("R7 software cannot set disable", d, 32'h0000_0000);

        // R6: counter fault
        @(negedge clk);
        u_par_buf_top.u_stat.spar_q[2] = ~u_par_buf_top.u_stat.spar_q[2];
        bus_read(2'd1, 10'h008, d);
        read_status(d);
        chk("R6 counter flag raised", d, 32'h0000_0002);

        // R4 R10: soft reset and recovery
        pulse_soft_rst();
        read_status(d);
        chk("R4 status after soft reset", d, 32'h0000_0300);
        bus_read(2'd0, 10'h070, d);
        chk("R10 buffer kept across soft reset", d, 32'hC0DE_0007);
        bus_read(2'd1, 10'h008, d);
        chk("R8 counters re-cleared", d, 32'd0);
        bus_read(2'd0, 10'h050, d);
        read_status(d);
        chk("R5 faulty row silent while disabled", d, 32'h0000_0300);
        fill_all(32'hBEEF_0000);
        bus_write(2'd2, 10'h000, 32'h0000_0300);
        bus_read(2'd0, 10'h050, d);
        chk("R10 refilled row data", d, 32'hBEEF_0005);
        read_status(d);
        chk("R10 no error after recovery", d, 32'h0000_0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule